// File: doc/BRIEF.md
# LED Matrix Scan Driver

This block lights an LED matrix of `ROWS` rows by `COLS` columns by time multiplexing. At any moment a single row line is active and the column lines carry the pattern for that row; the active row steps through the matrix in a fixed rotation, so every row is lit for one `ROWS`-th of each scan frame. At the default size of 8 by 8, each row is lit one eighth of the time. The dwell per row is the parameter `DWELL`, counted in clock cycles. The default of 250000 gives a 1 kHz row rate at 250 MHz.

A host loads one column word per row through a write port made of an address, data and an enable. Writes land in a shadow bank. The whole shadow bank is copied into the display bank in the single cycle in which the scan wraps from the last row back to row 0. A frame therefore never mixes old and new words, and a row never shows a word that is only half updated.

A two-state machine sequences each row:
- `ST_BLANK` lasts exactly one clock. It holds the columns dark while the row select has just moved, which prevents ghosting. It always goes on to `ST_SHOW`.
- `ST_SHOW` drives the active word for the remaining `DWELL-1` cycles. When the dwell counter expires it goes back to `ST_BLANK` and the row pointer advances.

Reset enters `ST_BLANK` at row 0.

Top module: `ledmx_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `row_sel` is 8'b0000_0001 and `col_drv` is 0. Both word banks reset to all zeros, so the first frame is dark.
- R2: `row_sel` always has exactly one bit set. Bit i set means row i is active.
- R3: Each row stays active for exactly `DWELL` cycles. Rows follow the order 0, 1, …, `ROWS-1`, then return to 0.
- R4: In the first cycle of every row (`ST_BLANK`), `col_drv` is 0. In the other `DWELL-1` cycles (`ST_SHOW`), `col_drv` equals the display-bank word of the active row.
- R5: Bit j of a row's word drives column j. A 1 lights the LED and a 0 leaves it dark.
- R6: A write (`wr_en` high at a rising edge) stores `wr_data` into the shadow word at `wr_addr`. It has no effect on `col_drv` until the next frame wrap.
- R7: At the edge that ends row `ROWS-1`, all shadow words are copied to the display bank together. If a row is written several times within one frame, the last write is the one shown.
- R8: A write at the same edge as the frame wrap goes into the shadow bank only. It becomes visible one frame later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write enable for the shadow bank |
| wr_addr | input | $clog2(ROWS) | Row index of the word being written |
| wr_data | input | COLS | Column word to store |
| row_sel | output | ROWS | One-hot active row select |
| col_drv | output | COLS | Column drive for the active row |

## Verification
The bench aims at the boundaries of a row and of a frame.

- **Blanking.** A driver that omitted the blank cycle would show the previous row's word under the new row select for one clock, or would lose a whole cycle of dwell. Both are caught by checking the first two cycles of every row against an all-ones pattern.
- **Shadow isolation.** Writes made mid-frame are checked to stay invisible until the wrap. A single-bank design would light the new word immediately, partway through a frame.
- **Write at the wrap edge.** A write placed exactly on the wrap edge separates a correct copy of the old shadow from a forwarding path that leaks the new data one frame early.
- **Repeated writes.** Rewriting one row twice in a frame confirms that the second value wins.

// File: rtl/ledmx_pkg.sv
package ledmx_pkg;

    // Per-row sequencing: one dark cycle, then the word is shown.
    typedef enum logic [0:0] {
        ST_BLANK = 1'b0,
        ST_SHOW  = 1'b1
    } scan_state_e;

endpackage

// File: rtl/ledmx_bank.sv
// Shadow and display word banks; the display bank is refreshed as a whole.
module ledmx_bank #(
    parameter int ROWS  = 8,
    parameter int COLS  = 8,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ROW_W-1:0] wr_addr,
    input  logic [COLS-1:0]  wr_data,
    input  logic             commit,
    input  logic [ROW_W-1:0] rd_idx,
    output logic [COLS-1:0]  rd_word
);

    logic [COLS-1:0] shadow_q [ROWS];
    logic [COLS-1:0] active_q [ROWS];

    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    shadow_q[r] <= '0;
                    active_q[r] <= '0;
                end else begin
                    if (wr_en && (wr_addr == ROW_W'(r))) begin
                        shadow_q[r] <= wr_data;
                    end
                    if (commit) begin
                        active_q[r] <= shadow_q[r];
                    end
                end
            end
        end
    endgenerate

    assign rd_word = active_q[rd_idx];

endmodule

// File: rtl/ledmx_scan.sv
// Dwell prescaler, row pointer and the blank/show state machine.
module ledmx_scan
    import ledmx_pkg::*;
#(
    parameter int ROWS  = 8,
    parameter int DWELL = 250000,
    localparam int ROW_W = $clog2(ROWS),
    localparam int CNT_W = (DWELL > 2) ? $clog2(DWELL) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [ROW_W-1:0] row_idx,
    output scan_state_e      state,
    output logic             frame_wrap
);

    logic [CNT_W-1:0] dwell_q;
    logic             dwell_done;
    logic             last_row;
    scan_state_e      state_d;

    assign dwell_done = (dwell_q == CNT_W'(DWELL - 1));
    assign last_row   = (row_idx == ROW_W'(ROWS - 1));
    assign frame_wrap = dwell_done && last_row;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_BLANK;
        end else begin
            state <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state;
        unique case (state)
            ST_BLANK: state_d = ST_SHOW;
            ST_SHOW:  if (dwell_done) state_d = ST_BLANK;
            default:  state_d = ST_BLANK;
        endcase
    end

    // Dwell counter and row pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dwell_q <= '0;
            row_idx <= '0;
        end else if (dwell_done) begin
            dwell_q <= '0;
            row_idx <= last_row ? '0 : row_idx + 1'b1;
        end else begin
            dwell_q <= dwell_q + 1'b1;
        end
    end

endmodule

// File: rtl/ledmx_drive.sv
// Output stage: one-hot row decode and blanked column drive.
module ledmx_drive
    import ledmx_pkg::*;
#(
    parameter int ROWS  = 8,
    parameter int COLS  = 8,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic [ROW_W-1:0] row_idx,
    input  scan_state_e      state,
    input  logic [COLS-1:0]  word,
    output logic [ROWS-1:0]  row_sel,
    output logic [COLS-1:0]  col_drv
);

    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_dec
            assign row_sel[r] = (row_idx == ROW_W'(r));
        end
    endgenerate

    always_comb begin
        unique case (state)
            ST_SHOW:  col_drv = word;
            ST_BLANK: col_drv = '0;
            default:  col_drv = '0;
        endcase
    end

endmodule

// File: rtl/ledmx_top.sv
module ledmx_top
    import ledmx_pkg::*;
#(
    parameter int ROWS  = 8,
    parameter int COLS  = 8,
    parameter int DWELL = 250000,
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ROW_W-1:0] wr_addr,
    input  logic [COLS-1:0]  wr_data,
    output logic [ROWS-1:0]  row_sel,
    output logic [COLS-1:0]  col_drv
);

    logic [ROW_W-1:0] row_idx;
    scan_state_e      state;
    logic             frame_wrap;
    logic [COLS-1:0]  word;

    ledmx_scan #(.ROWS(ROWS), .DWELL(DWELL)) scan_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .row_idx    (row_idx),
        .state      (state),
        .frame_wrap (frame_wrap)
    );

    ledmx_bank #(.ROWS(ROWS), .COLS(COLS)) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .commit  (frame_wrap),
        .rd_idx  (row_idx),
        .rd_word (word)
    );

    ledmx_drive #(.ROWS(ROWS), .COLS(COLS)) drive_i (
        .row_idx (row_idx),
        .state   (state),
        .word    (word),
        .row_sel (row_sel),
        .col_drv (col_drv)
    );

endmodule

// File: rtl/ledmx_chk.sv
module ledmx_chk #(
    parameter int ROWS  = 8,
    parameter int COLS  = 8,
    parameter int DWELL = 250000
) (
    input logic            clk,
    input logic            rst_n,
    input logic [ROWS-1:0] row_sel,
    input logic [COLS-1:0] col_drv
);

    logic [ROWS-1:0] row_q;
    int              held;

    // Cycles the current row select has been held, counted from the change.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q <= ROWS'(1);
            held  <= 0;
        end else begin
            row_q <= row_sel;
            held  <= (row_sel != row_q) ? 1 : held + 1;
        end
    end

    AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(row_sel) == 1);                                            // R2

    AST_ROW_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(row_sel) |->
            row_sel == {$past(row_sel[ROWS-2:0]), $past(row_sel[ROWS-1])});   // R3

    AST_DWELL_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (row_sel != row_q) |-> held == DWELL);                                // R3

    AST_DWELL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        held <= DWELL);                                                       // R3

    AST_BLANK_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(row_sel) |-> col_drv == '0);                                 // R4

    AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(row_sel) && $past(col_drv) != '0) |-> $stable(col_drv));     // R6

endmodule

bind ledmx_top ledmx_chk #(.ROWS(ROWS), .COLS(COLS), .DWELL(DWELL)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .row_sel (row_sel),
    .col_drv (col_drv)
);

// File: tb/ledmx_top_tb_top.sv
module ledmx_top_tb_top;

    localparam int ROWS  = 8;
    localparam int COLS  = 8;
    localparam int D     = 5;
    localparam int FRAME = ROWS * D;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            wr_en;
    logic [2:0]      wr_addr;
    logic [COLS-1:0] wr_data;
    logic [ROWS-1:0] row_sel;
    logic [COLS-1:0] col_drv;

    always #2 clk = ~clk;

    ledmx_top #(.ROWS(ROWS), .COLS(COLS), .DWELL(D)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .row_sel (row_sel),
        .col_drv (col_drv)
    );

    // Reference model built from the requirements.
    int              n;
    logic [COLS-1:0] sh_m [ROWS];
    logic [COLS-1:0] ac_m [ROWS];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n <= 0;
            for (int i = 0; i < ROWS; i++) begin
                sh_m[i] <= '0;
                ac_m[i] <= '0;
            end
        end else begin
            n <= n + 1;
            if (wr_en) sh_m[wr_addr] <= wr_data;
            if (n % FRAME == FRAME - 1)
                for (int i = 0; i < ROWS; i++) ac_m[i] <= sh_m[i];
        end
    end

    int checks = 0;
    int fails  = 0;

    function automatic logic [ROWS-1:0] exp_row();
        return ROWS'(1) << ((n / D) % ROWS);
    endfunction

    function automatic logic [COLS-1:0] exp_col();
        return (n % D == 0) ? '0 : ac_m[(n / D) % ROWS];
    endfunction

    task automatic chk8(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, n);
        end
    endtask

    task automatic step(int k);
        repeat (k) begin
            @(negedge clk);
            chk8("R2/R3 row_sel", row_sel, exp_row());
            chk8("R4/R5 col_drv", col_drv, exp_col());
        end
    endtask

    task automatic go_to(int phase);
        do step(1); while (n % FRAME != phase);
    endtask

    task automatic wr(int a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        #7;
        chk8("R1 row_sel in reset", row_sel, 8'h01);
        chk8("R1 col_drv in reset", col_drv, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        chk8("R1 row_sel after reset", row_sel, 8'h01);
        chk8("R1 col_drv after reset", col_drv, 8'h00);
        for (int i = 0; i < FRAME; i++) begin
            step(1);
            chk8("R1 first frame dark", col_drv, 8'h00);
        end
    endtask

    task automatic t_shadow_hold();
        go_to(1);
        wr(2, 8'hA5);
        go_to(2 * D + 1);
        chk8("R6 write hidden mid-frame", col_drv, 8'h00);
        go_to(0);
        go_to(2 * D + 1);
        chk8("R6 row 2 after wrap", col_drv, 8'hA5);
        chk8("R5 row 2 select", row_sel, 8'h04);
    endtask

    task automatic t_scan_patterns();
        logic [7:0] pat [ROWS] = '{8'h01, 8'h80, 8'h3C, 8'hC3, 8'h55, 8'hAA, 8'h0F, 8'hF0};
        go_to(1);
        for (int r = 0; r < ROWS; r++) wr(r, pat[r]);
        go_to(0);
        for (int r = 0; r < ROWS; r++) begin
            go_to(r * D + 2);
            chk8("R5 pattern column bits", col_drv, pat[r]);
        end
        step(FRAME);
    endtask

    task automatic t_blank();
        go_to(1);
        for (int r = 0; r < ROWS; r++) wr(r, 8'hFF);
        go_to(0);
        for (int r = 0; r < ROWS; r++) begin
            go_to(r * D);
            chk8("R4 blank at row start", col_drv, 8'h00);
            chk8("R3 row select at start", row_sel, 8'(1 << r));
            step(1);
            chk8("R4 show after blank", col_drv, 8'hFF);
        end
    endtask

    task automatic t_wrap_write();
        go_to(FRAME - 1);
        wr(0, 8'h3C);
        go_to(1);
        chk8("R8 wrap-edge write deferred", col_drv, 8'hFF);
        go_to(0);
        go_to(1);
        chk8("R8 wrap-edge write next frame", col_drv, 8'h3C);
    endtask

    task automatic t_last_wins();
        go_to(3);
        wr(5, 8'h11);
        wr(5, 8'h22);
        wr(6, 8'h99);
        go_to(0);
        go_to(5 * D + 3);
        chk8("R7 last write wins", col_drv, 8'h22);
        go_to(6 * D + 3);
        chk8("R7 rows commit together", col_drv, 8'h99);
        step(FRAME);
    endtask

    task automatic t_mid_reset();
        go_to(3 * D + 2);
        rst_n = 1'b0;
        #1;
        chk8("R1 async reset row_sel", row_sel, 8'h01);
        chk8("R1 async reset col_drv", col_drv, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        step(FRAME);
        chk8("R1 banks cleared", col_drv, 8'h00);
    endtask

    logic done = 1'b0;

    initial begin
        t_reset();
        t_shadow_hold();
        t_scan_patterns();
        t_blank();
        t_wrap_write();
        t_last_wins();
        t_mid_reset();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1-to-end run actual=hung expected=complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule